// File: doc/BRIEF.md
# Accumulator Fetch-Execute Processor

This block is a small single-accumulator processor. It runs a fixed instruction cycle in which a fetch phase is always followed by an execute phase. Instructions and data are both 16-bit words. Memory is reached through a 12-bit word address, so up to 4096 words can be addressed. The block drives a synchronous word-wide memory from two internal registers. The address register supplies the memory address, and the buffer register supplies the write data. Read data comes back one cycle after the address is presented.

Each instruction word carries a 4-bit operation code in its top bits and a direct 12-bit operand address in its low bits. The operations are:

- load the accumulator from memory;
- store the accumulator to memory;
- add a memory word to the accumulator;
- jump unconditionally;
- halt.

All other codes do nothing. Data words are sign-magnitude: bit 15 is the sign and bits 14:0 are the magnitude. The program counter, instruction register and accumulator are brought out for observation, together with a halt flag.

After a synchronous reset, execution starts at the address given by a reset-vector input. It continues until a halt instruction is decoded.

Top module: `acc_proc`

## Requirements
- R1: While `rst` is high at a clock edge, PC loads `reset_vec`, AC and IR clear to 0, and `halted` and `mem_we` are 0.
- R2: Each instruction cycle first reads the word at PC into IR and advances PC by one. Both are visible three cycles after the cycle starts.
- R3: Opcode 0x1 (bits 15:12) copies the word at the address in bits 11:0 into AC unchanged, including its sign bit.
- R4: Opcode 0x2 writes AC to the address in bits 11:0. `mem_we` is high only for a store, and `mem_wdata` then equals AC.
- R5: Opcode 0x5 with operands of equal sign adds the 15-bit magnitudes and keeps that sign.
- R6: Opcode 0x5 with operands of different sign subtracts the smaller magnitude from the larger and takes the sign of the larger operand.
- R7: An add whose resulting magnitude is zero yields 0x0000, never 0x8000.
- R8: A same-sign magnitude sum that overflows is reduced modulo 2^15, and the sign is kept unless the result is zero.
- R9: Opcode 0x8 sets PC to bits 11:0, and the next fetch reads from there.
- R10: Opcode 0x0 raises `halted`. After that, PC, AC, IR and `mem_addr` stay frozen and no write occurs until reset.
- R11: Any other opcode leaves AC unchanged, and execution continues at PC+1.
- R12: Running 0x1940, 0x5941, 0x2941 and then a halt word from 0x300 leaves memory[0x941] equal to the R5–R8 sum of the old 0x940 and 0x941. AC holds the same value, and PC reads 0x304 after the halt word at 0x303 is fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_vec | input | 12 | Start address loaded into PC on reset |
| mem_addr | output | 12 | Registered memory word address |
| mem_wdata | output | 16 | Registered write data (buffer register) |
| mem_we | output | 1 | Registered write enable |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| halted | output | 1 | High once a halt has been decoded |
| pc_o | output | 12 | Program counter |
| ir_o | output | 16 | Instruction register |
| ac_o | output | 16 | Accumulator |

## Verification
Every instruction starts with three cycles: issue the address, read the memory, then load IR and PC. The fourth cycle decodes the instruction. That is the edge where a jump changes PC and where `halted` rises. Loads and adds update AC on the sixth edge. Stores write memory on the fifth edge, and jumps, halts and no-ops end after four. The directed test counts falling edges from reset release and samples at those offsets. Whole-program tests wait for `halted` and then read memory and AC, so a late or early result is seen as a wrong value at a fixed sampling point.

// File: rtl/acc_pkg.sv
package acc_pkg;
  typedef enum logic [2:0] {
    ST_FADDR,
    ST_FREAD,
    ST_DECODE,
    ST_OADDR,
    ST_OPRW,
    ST_EXEC,
    ST_HALT
  } state_t;

  localparam logic [3:0] OP_HALT  = 4'h0;
  localparam logic [3:0] OP_LOAD  = 4'h1;
  localparam logic [3:0] OP_STORE = 4'h2;
  localparam logic [3:0] OP_ADD   = 4'h5;
  localparam logic [3:0] OP_JUMP  = 4'h8;
endpackage

// File: rtl/acc_sm_add.sv
module acc_sm_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  localparam int MW = W - 1;

  logic [MW-1:0] ma, mb, mr;
  logic          sr;

  always_comb begin
    ma = a[MW-1:0];
    mb = b[MW-1:0];
    if (a[W-1] == b[W-1]) begin
      mr = ma + mb;
      sr = a[W-1];
    end else if (ma >= mb) begin
      mr = ma - mb;
      sr = a[W-1];
    end else begin
      mr = mb - ma;
      sr = b[W-1];
    end
    if (mr == '0) sr = 1'b0;
    sum = {sr, mr};
  end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl #(
  parameter int OPW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] op,
  output logic           mar_from_pc,
  output logic           ir_load,
  output logic           mar_from_ir,
  output logic           mbr_from_ac,
  output logic           we_set,
  output logic           pc_jump,
  output logic           set_halt,
  output logic           ac_load,
  output logic           ac_add
);
  import acc_pkg::*;

  state_t state, nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FADDR;
    else     state <= nxt;
  end

  always_comb begin
    nxt         = state;
    mar_from_pc = 1'b0;
    ir_load     = 1'b0;
    mar_from_ir = 1'b0;
    mbr_from_ac = 1'b0;
    we_set      = 1'b0;
    pc_jump     = 1'b0;
    set_halt    = 1'b0;
    ac_load     = 1'b0;
    ac_add      = 1'b0;
    case (state)
      ST_FADDR: begin
        mar_from_pc = 1'b1;
        nxt         = ST_FREAD;
      end
      ST_FREAD: nxt = ST_DECODE;
      ST_DECODE: begin
        ir_load = 1'b1;
        nxt     = ST_OADDR;
      end
      ST_OADDR: begin
        case (op)
          OP_HALT: begin
            set_halt = 1'b1;
            nxt      = ST_HALT;
          end
          OP_JUMP: begin
            pc_jump = 1'b1;
            nxt     = ST_FADDR;
          end
          OP_LOAD, OP_ADD: begin
            mar_from_ir = 1'b1;
            nxt         = ST_OPRW;
          end
          OP_STORE: begin
            mar_from_ir = 1'b1;
            mbr_from_ac = 1'b1;
            we_set      = 1'b1;
            nxt         = ST_OPRW;
          end
          default: nxt = ST_FADDR;
        endcase
      end
      ST_OPRW: nxt = (op == OP_STORE) ? ST_FADDR : ST_EXEC;
      ST_EXEC: begin
        ac_load = (op == OP_LOAD);
        ac_add  = (op == OP_ADD);
        nxt     = ST_FADDR;
      end
      ST_HALT: nxt = ST_HALT;
      default: nxt = ST_FADDR;
    endcase
  end
endmodule

// File: rtl/acc_proc.sv
module acc_proc #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] reset_vec,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic          halted,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] ir_o,
  output logic [DW-1:0] ac_o
);
  localparam int OPW = DW - AW;

  logic [AW-1:0] pc, mar;
  logic [DW-1:0] ir, ac, mbr, sum;
  logic          we_q, halt_q;
  logic          mar_from_pc, ir_load, mar_from_ir, mbr_from_ac;
  logic          we_set, pc_jump, set_halt, ac_load, ac_add;

  acc_ctrl #(.OPW(OPW)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .op          (ir[DW-1:AW]),
    .mar_from_pc (mar_from_pc),
    .ir_load     (ir_load),
    .mar_from_ir (mar_from_ir),
    .mbr_from_ac (mbr_from_ac),
    .we_set      (we_set),
    .pc_jump     (pc_jump),
    .set_halt    (set_halt),
    .ac_load     (ac_load),
    .ac_add      (ac_add)
  );

  acc_sm_add #(.W(DW)) u_add (
    .a   (ac),
    .b   (mem_rdata),
    .sum (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= reset_vec;
      ir     <= '0;
      ac     <= '0;
      mar    <= '0;
      mbr    <= '0;
      we_q   <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      we_q <= we_set;
      if (set_halt)    halt_q <= 1'b1;
      if (mar_from_pc) mar <= pc;
      if (mar_from_ir) mar <= ir[AW-1:0];
      if (ir_load) begin
        ir  <= mem_rdata;
        mbr <= mem_rdata;
        pc  <= pc + AW'(1);
      end
      if (pc_jump)     pc  <= ir[AW-1:0];
      if (mbr_from_ac) mbr <= ac;
      if (ac_load) begin
        ac  <= mem_rdata;
        mbr <= mem_rdata;
      end
      if (ac_add) begin
        ac  <= sum;
        mbr <= mem_rdata;
      end
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign mem_we    = we_q;
  assign halted    = halt_q;
  assign pc_o      = pc;
  assign ir_o      = ir;
  assign ac_o      = ac;
endmodule

// File: rtl/acc_proc_chk.sv
module acc_proc_chk #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_we,
  input logic          halted,
  input logic [AW-1:0] pc_o,
  input logic [DW-1:0] ir_o,
  input logic [DW-1:0] ac_o
);
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !mem_we && $stable(pc_o) && $stable(ac_o) && $stable(mem_addr))); // R10

  AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> (ir_o[DW-1:AW] == 4'h0)); // R10

  AST_STORE_WRITE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wdata == ac_o && ir_o[DW-1:AW] == 4'h2)); // R4

  AST_PC_FLOW: assert property (@(posedge clk) disable iff (rst)
    (pc_o != $past(pc_o)) |-> (pc_o == $past(pc_o) + AW'(1) || pc_o == $past(ir_o[AW-1:0]))); // R2 R9

  AST_AC_WRITERS: assert property (@(posedge clk) disable iff (rst)
    (ac_o != $past(ac_o)) |-> ($past(ir_o[DW-1:AW]) == 4'h1 || $past(ir_o[DW-1:AW]) == 4'h5)); // R11
endmodule

bind acc_proc acc_proc_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_we    (mem_we),
  .halted    (halted),
  .pc_o      (pc_o),
  .ir_o      (ir_o),
  .ac_o      (ac_o)
);

// File: tb/acc_proc_tb_top.sv
module acc_proc_tb_top;
  localparam int DW = 16;
  localparam int AW = 12;
  localparam int NV = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] reset_vec = 12'h300;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, ir_o, ac_o;
  logic          mem_we, halted;
  logic [AW-1:0] pc_o;
  logic [DW-1:0] mem [1 << AW];

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  acc_proc #(.DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .reset_vec(reset_vec),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .halted(halted),
    .pc_o(pc_o), .ir_o(ir_o), .ac_o(ac_o)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  // {tag, a, b, expected sum}
  localparam logic [51:0] VEC [NV] = '{
    {4'd5, 16'h0003, 16'h0004, 16'h0007},
    {4'd5, 16'h8003, 16'h8004, 16'h8007},
    {4'd6, 16'h0009, 16'h8004, 16'h0005},
    {4'd6, 16'h0004, 16'h8009, 16'h8005},
    {4'd6, 16'h8009, 16'h0004, 16'h8005},
    {4'd7, 16'h0005, 16'h8005, 16'h0000},
    {4'd7, 16'h8000, 16'h8000, 16'h0000},
    {4'd8, 16'h7FFF, 16'h0002, 16'h0001},
    {4'd8, 16'hFFFF, 16'h8003, 16'h8002}
  };

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [AW-1:0] v);
    rst       = 1'b1;
    reset_vec = v;
    step(3);
    chk("R1 pc",     DW'(pc_o), DW'(v));
    chk("R1 ac",     ac_o, 16'h0000);
    chk("R1 ir",     ir_o, 16'h0000);
    chk("R1 halted", DW'(halted), 16'h0000);
    chk("R1 we",     DW'(mem_we), 16'h0000);
    rst = 1'b0;
  endtask

  task automatic run_to_halt();
    for (int i = 0; i < 400 && !halted; i++) step(1);
    chk("R10 reached halt", DW'(halted), 16'h0001);
  endtask

  initial begin
    rst = 1'b1;
    step(1);

    // Table walk: example program over sign-magnitude operand pairs
    for (int i = 0; i < NV; i++) begin
      mem[12'h300] = 16'h1940;
      mem[12'h301] = 16'h5941;
      mem[12'h302] = 16'h2941;
      mem[12'h303] = 16'h0000;
      mem[12'h940] = VEC[i][47:32];
      mem[12'h941] = VEC[i][31:16];
      do_reset(12'h300);
      run_to_halt();
      chk({"R12 mem ", tag_name(VEC[i][51:48])}, mem[12'h941], VEC[i][15:0]);
      chk({"R12 ac ",  tag_name(VEC[i][51:48])}, ac_o, VEC[i][15:0]);
      chk("R12 pc", DW'(pc_o), 16'h0304);
    end

    // R3: load keeps the sign bit; R4: store copies AC
    mem[12'h500] = 16'h1A10;
    mem[12'h501] = 16'h2A11;
    mem[12'h502] = 16'h0000;
    mem[12'hA10] = 16'h8123;
    mem[12'hA11] = 16'h0000;
    do_reset(12'h500);
    run_to_halt();
    chk("R3 load", ac_o, 16'h8123);
    chk("R4 store", mem[12'hA11], 16'h8123);

    // Timed walk: load, nop, jump, halt
    mem[12'h300] = 16'h1940;
    mem[12'h301] = 16'h7000;
    mem[12'h302] = 16'h8200;
    mem[12'h200] = 16'h0000;
    mem[12'h940] = 16'h0042;
    do_reset(12'h300);
    step(3);
    chk("R2 ir",  ir_o, 16'h1940);
    chk("R2 pc",  DW'(pc_o), 16'h0301);
    step(3);
    chk("R3 ac",  ac_o, 16'h0042);
    step(3);
    chk("R2 ir nop", ir_o, 16'h7000);
    step(1);
    chk("R11 ac", ac_o, 16'h0042);
    chk("R11 pc", DW'(pc_o), 16'h0302);
    step(3);
    chk("R2 ir jump", ir_o, 16'h8200);
    step(1);
    chk("R9 pc",  DW'(pc_o), 16'h0200);
    step(3);
    chk("R9 ir",  ir_o, 16'h0000);
    chk("R9 pc+1", DW'(pc_o), 16'h0201);
    chk("R10 not yet", DW'(halted), 16'h0000);
    step(1);
    chk("R10 halted", DW'(halted), 16'h0001);
    step(10);
    chk("R10 pc",   DW'(pc_o), 16'h0201);
    chk("R10 ac",   ac_o, 16'h0042);
    chk("R10 addr", DW'(mem_addr), 16'h0200);
    chk("R10 we",   DW'(mem_we), 16'h0000);

    // R1: reset after halt with another vector
    do_reset(12'h123);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule